// File: doc/BRIEF.md
# Partitioned SEC-DED Buffer Memory

This block is a 128-word, 32-bit staging memory for a flash controller. Every stored word is protected by a single-error-correct, double-error-detect code. The memory is divided at a programmable boundary. Words below the boundary hold data fetched for read transfers, and words at or above it hold data waiting to be written out. Clients address each region by an offset relative to that region's start, using one write port and one read port, and a select bit picks the region. The boundary is given as the size of the lower region in 32-bit words, so a value of 1 gives the lower region four bytes.

The read port has a latency of one cycle. Each read result carries a pulse that marks a corrected single-bit error or a detected uncorrectable error. Two test requests corrupt the next stored word on purpose: one flips one data bit and the other flips two. Each request is used up by that one write. The error reporting can therefore be tested without real memory faults.

Top module: `ecc_part_buf`

## Requirements
- R1: A word written through either port mode reads back unchanged. `rdValid` is high for exactly the cycle after a sampled `rdEn`, and `rdData` is valid in that same cycle.
- R2: With `rdPartSel`/`wrPartSel` = 0 (lower region), offset o maps to word o. With select = 1 (upper region), offset o maps to word B+o, where B is `rdPartSize` limited to 128. The lower region holds B words and the upper region holds 128-B words.
- R3: An offset at or beyond its region's size S is folded back once to o-S. The fold is defined for o < 2S, and every access stays inside its own region.
- R4: A read or write aimed at a region of size zero is ignored. No word changes and no `rdValid` is produced. A `rdPartSize` above 128 gives an empty upper region.
- R5: A stored word with one flipped data bit reads back with the original data, and `corrErr` pulses with it.
- R6: A stored word with two flipped data bits raises `uncErr`. `rdData` then carries the stored data bits uncorrected.
- R7: A pulse on `injSingle` inverts data bit 0 of the next accepted write only. This includes a write in the same cycle as the pulse. Later writes are stored clean.
- R8: A pulse on `injDouble` inverts data bits 0 and 1 of the next accepted write only. When both requests are pending, the double request wins.
- R9: `corrErr` and `uncErr` are never high together and are only high while `rdValid` is high. A clean word raises neither.
- R10: When a read and a write hit the same word in one cycle, the read returns the word's previous contents. The new word is visible to the next read.
- R11: While reset is asserted (`rst_n` low), `rdValid`, `corrErr` and `uncErr` are low and pending injection requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdPartSize | input | 8 | Lower-region size in 32-bit words (limited to 128) |
| wrEn | input | 1 | Write request |
| wrPartSel | input | 1 | Write region: 0 lower, 1 upper |
| wrAddr | input | 7 | Write offset within the region |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read request |
| rdPartSel | input | 1 | Read region: 0 lower, 1 upper |
| rdAddr | input | 7 | Read offset within the region |
| injSingle | input | 1 | Request a one-bit corruption of the next write |
| injDouble | input | 1 | Request a two-bit corruption of the next write |
| rdData | output | 32 | Read data, corrected where possible |
| rdValid | output | 1 | Read result valid |
| corrErr | output | 1 | Corrected single-bit error on this result |
| uncErr | output | 1 | Uncorrectable error on this result |

## Verification
The write and the read of one physical word can land in the same clock. The bench drives both ports at the same lower-region offset in a single cycle and expects the word from before the write. A following read must then return the new word. An injection request can also coincide with a write's selection of the target word. The bench arms single, double and combined requests, then judges both the data and the `corrErr`/`uncErr` pulse pattern on the following reads, including that a second write is stored clean.

// File: rtl/ecc_buf_pkg.sv
package ecc_buf_pkg;

  localparam int DATA_W = 32;
  localparam int HAM_W  = $clog2(DATA_W + $clog2(DATA_W) + 1);
  localparam int CODE_W = DATA_W + HAM_W + 1;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
    logic flipOne;
    logic flipTwo;
  } bufStrobes_t;

  // Hamming position of data bit i: the i-th position (from 3) that is not a power of two
  function automatic int dataPos(input int i);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == i) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] hamBits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      int pos;
      pos = dataPos(i);
      for (int k = 0; k < HAM_W; k++) begin
        if (pos[k] && d[i]) h[k] = ~h[k];
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/ecc_buf_amap.sv
module ecc_buf_amap #(
  parameter int ADDR_W = 7,
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              upper,
  input  logic [PTR_W-1:0]  base,
  input  logic [PTR_W-1:0]  loSize,
  input  logic [PTR_W-1:0]  hiSize,
  output logic [ADDR_W-1:0] idx,
  output logic              ok
);

  logic [PTR_W-1:0] regSize;
  logic [PTR_W-1:0] off;
  logic [PTR_W-1:0] full;

  always_comb begin
    regSize = upper ? hiSize : loSize;
    off     = {1'b0, offset};
    if (off >= regSize) off = off - regSize;
    full = upper ? (base + off) : off;
    idx  = full[ADDR_W-1:0];
    ok   = (regSize != '0);
  end

endmodule

// File: rtl/ecc_buf_ctrl.sv
module ecc_buf_ctrl
  import ecc_buf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  rdPartSize,
  input  logic              wrEn,
  input  logic              wrPartSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic              rdPartSel,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              injSingle,
  input  logic              injDouble,
  output bufStrobes_t       strb,
  output logic [ADDR_W-1:0] wrIdx,
  output logic [ADDR_W-1:0] rdIdx,
  output logic              pendOne,
  output logic              pendTwo
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam int NPORT = 2;  // 0: write port, 1: read port

  logic [PTR_W-1:0]  base;
  logic [PTR_W-1:0]  hiSize;
  logic [ADDR_W-1:0] portOff [NPORT];
  logic              portSel [NPORT];
  logic [ADDR_W-1:0] portIdx [NPORT];
  logic              portOk  [NPORT];

  assign base   = (rdPartSize > DEPTH_P) ? DEPTH_P : rdPartSize;
  assign hiSize = DEPTH_P - base;

  assign portOff[0] = wrAddr;
  assign portSel[0] = wrPartSel;
  assign portOff[1] = rdAddr;
  assign portSel[1] = rdPartSel;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    ecc_buf_amap #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_amap (
      .offset (portOff[g]),
      .upper  (portSel[g]),
      .base   (base),
      .loSize (base),
      .hiSize (hiSize),
      .idx    (portIdx[g]),
      .ok     (portOk[g])
    );
  end

  assign wrIdx = portIdx[0];
  assign rdIdx = portIdx[1];

  always_comb begin
    strb.wrStb   = wrEn & portOk[0];
    strb.rdStb   = rdEn & portOk[1];
    strb.flipTwo = strb.wrStb & (pendTwo | injDouble);
    strb.flipOne = strb.wrStb & (pendOne | injSingle) & ~strb.flipTwo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendOne <= 1'b0;
      pendTwo <= 1'b0;
    end else if (strb.wrStb) begin
      pendOne <= 1'b0;
      pendTwo <= 1'b0;
    end else begin
      pendOne <= pendOne | injSingle;
      pendTwo <= pendTwo | injDouble;
    end
  end

endmodule

// File: rtl/ecc_buf_dp.sv
module ecc_buf_dp
  import ecc_buf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bufStrobes_t       strb,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [ADDR_W-1:0] rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              corrErr,
  output logic              uncErr
);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [CODE_W-1:0] wrCode;
  logic [CODE_W-1:0] flipMask;
  logic [HAM_W-1:0]  wrHam;
  logic [CODE_W-1:0] rdWord;
  logic              rdVld;

  logic [DATA_W-1:0] storedD;
  logic [HAM_W-1:0]  storedH;
  logic [HAM_W-1:0]  syn;
  logic              pErr;
  logic [DATA_W-1:0] fixD;

  // Encoder: {overall parity, check bits, data}
  always_comb begin
    wrHam    = hamBits(wrData);
    wrCode   = {^{wrHam, wrData}, wrHam, wrData};
    flipMask = CODE_W'({strb.flipTwo, strb.flipOne | strb.flipTwo});
  end

  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[wrIdx] <= wrCode ^ flipMask;
  end

  always_ff @(posedge clk) begin
    if (strb.rdStb) rdWord <= mem[rdIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdVld <= 1'b0;
    else        rdVld <= strb.rdStb;
  end

  // Decoder
  always_comb begin
    storedD = rdWord[DATA_W-1:0];
    storedH = rdWord[DATA_W +: HAM_W];
    syn     = hamBits(storedD) ^ storedH;
    pErr    = ^rdWord;
    fixD    = storedD;
    for (int i = 0; i < DATA_W; i++) begin
      if (pErr && (dataPos(i) == int'(syn))) fixD[i] = ~fixD[i];
    end
  end

  assign rdData  = fixD;
  assign rdValid = rdVld;
  assign corrErr = rdVld & pErr;
  assign uncErr  = rdVld & ~pErr & (syn != '0);

endmodule

// File: rtl/ecc_part_buf.sv
module ecc_part_buf
  import ecc_buf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  rdPartSize,
  input  logic              wrEn,
  input  logic              wrPartSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdPartSel,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              injSingle,
  input  logic              injDouble,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              corrErr,
  output logic              uncErr
);

  bufStrobes_t       strb;
  logic [ADDR_W-1:0] wrIdx;
  logic [ADDR_W-1:0] rdIdx;
  logic              pendOne;
  logic              pendTwo;

  ecc_buf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdPartSize (rdPartSize),
    .wrEn       (wrEn),
    .wrPartSel  (wrPartSel),
    .wrAddr     (wrAddr),
    .rdEn       (rdEn),
    .rdPartSel  (rdPartSel),
    .rdAddr     (rdAddr),
    .injSingle  (injSingle),
    .injDouble  (injDouble),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx),
    .pendOne    (pendOne),
    .pendTwo    (pendTwo)
  );

  ecc_buf_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrIdx   (wrIdx),
    .rdIdx   (rdIdx),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .corrErr (corrErr),
    .uncErr  (uncErr)
  );

endmodule

// File: rtl/ecc_part_buf_chk.sv
module ecc_part_buf_chk
  import ecc_buf_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PTR_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PTR_W-1:0]  rdPartSize,
  input logic              wrPartSel,
  input logic              rdEn,
  input logic              rdPartSel,
  input logic              rdValid,
  input logic              corrErr,
  input logic              uncErr,
  input bufStrobes_t       strb,
  input logic [ADDR_W-1:0] wrIdx,
  input logic              pendOne,
  input logic              pendTwo
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  logic [PTR_W-1:0] chkBase;
  assign chkBase = (rdPartSize > DEPTH_P) ? DEPTH_P : rdPartSize;

  p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(rdEn));

  p_rdstb_gives_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdStb |=> rdValid);

  p_upper_write_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStb && wrPartSel) |-> ({1'b0, wrIdx} >= chkBase));

  p_lower_write_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStb && !wrPartSel) |-> ({1'b0, wrIdx} < chkBase));

  p_empty_lower_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !rdPartSel && rdPartSize == '0) |=> !rdValid);

  p_flip_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.flipOne || strb.flipTwo) |-> strb.wrStb);

  p_inject_used_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStb |=> (!pendOne && !pendTwo));

  p_flip_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.flipOne && strb.flipTwo));

  p_err_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(corrErr && uncErr));

  p_err_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (corrErr || uncErr) |-> rdValid);

endmodule

bind ecc_part_buf ecc_part_buf_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_chk (.*);

// File: tb/test_ecc_part_buf.sv
`timescale 1ns/1ps
module test_ecc_part_buf;

  localparam int DEPTH  = 128;
  localparam int ADDR_W = 7;
  localparam int PTR_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PTR_W-1:0]  rdPartSize = '0;
  logic              wrEn = 1'b0;
  logic              wrPartSel = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic              rdEn = 1'b0;
  logic              rdPartSel = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              injSingle = 1'b0;
  logic              injDouble = 1'b0;
  logic [31:0]       rdData;
  logic              rdValid;
  logic              corrErr;
  logic              uncErr;

  always #2.5 clk = ~clk;

  ecc_part_buf #(.DEPTH(DEPTH)) i_ecc_part_buf (
    .clk(clk), .rst_n(rst_n), .rdPartSize(rdPartSize),
    .wrEn(wrEn), .wrPartSel(wrPartSel), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdPartSel(rdPartSel), .rdAddr(rdAddr),
    .injSingle(injSingle), .injDouble(injDouble),
    .rdData(rdData), .rdValid(rdValid), .corrErr(corrErr), .uncErr(uncErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expD [$];
  logic [1:0]  expF [$];   // {uncErr, corrErr}
  string       expT [$];
  logic [31:0] mdl  [DEPTH];
  int          kind [DEPTH];  // 0 clean, 1 one bit flipped, 2 two bits flipped
  bit pOne = 0;
  bit pTwo = 0;
  int curSize = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int baseOf();
    return (curSize > DEPTH) ? DEPTH : curSize;
  endfunction

  function automatic int sizeOf(input bit sel);
    return sel ? (DEPTH - baseOf()) : baseOf();
  endfunction

  function automatic int physOf(input bit sel, input int off);
    int sz;
    int o;
    sz = sizeOf(sel);
    o  = (off >= sz) ? off - sz : off;
    return sel ? baseOf() + o : o;
  endfunction

  // Monitor: pops the scoreboard whenever a result appears
  logic [31:0] mD;
  logic [1:0]  mF;
  string       mT;
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      if (expD.size() == 0) begin
        check(1'b0, "R1 unexpected rdValid", 32'd1, 32'd0);
      end else begin
        mD = expD.pop_front();
        mF = expF.pop_front();
        mT = expT.pop_front();
        check(rdData == mD, {mT, " data"}, rdData, mD);
        check({uncErr, corrErr} == mF, {mT, " error flags"}, {30'd0, uncErr, corrErr}, {30'd0, mF});
      end
    end else if (corrErr || uncErr) begin
      check(1'b0, "R9 error pulse without rdValid", {30'd0, uncErr, corrErr}, 32'd0);
    end
  end

  task automatic setSize(input int s);
    @(negedge clk);
    rdPartSize = PTR_W'(s);
    curSize = s;
  endtask

  task automatic wr(input bit sel, input int off, input logic [31:0] d);
    int ph;
    @(negedge clk);
    wrEn = 1'b1; wrPartSel = sel; wrAddr = ADDR_W'(off); wrData = d;
    if (sizeOf(sel) != 0) begin
      ph = physOf(sel, off);
      mdl[ph]  = d;
      kind[ph] = pTwo ? 2 : (pOne ? 1 : 0);
      pOne = 0;
      pTwo = 0;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pushExp(input int ph, input string tag);
    expD.push_back(kind[ph] == 2 ? (mdl[ph] ^ 32'h3) : mdl[ph]);
    expF.push_back(kind[ph] == 2 ? 2'b10 : (kind[ph] == 1 ? 2'b01 : 2'b00));
    expT.push_back(tag);
  endtask

  task automatic rd(input bit sel, input int off, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdPartSel = sel; rdAddr = ADDR_W'(off);
    pushExp(physOf(sel, off), tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdIgnored(input bit sel, input int off, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdPartSel = sel; rdAddr = ADDR_W'(off);
    @(negedge clk);
    rdEn = 1'b0;
    check(rdValid == 1'b0, {tag, " read of empty region ignored"}, {31'd0, rdValid}, 32'd0);
  endtask

  task automatic rdwr(input bit sel, input int off, input logic [31:0] d, input string tag);
    int ph;
    @(negedge clk);
    ph = physOf(sel, off);
    rdEn = 1'b1; rdPartSel = sel; rdAddr = ADDR_W'(off);
    wrEn = 1'b1; wrPartSel = sel; wrAddr = ADDR_W'(off); wrData = d;
    pushExp(ph, tag);
    mdl[ph]  = d;
    kind[ph] = pTwo ? 2 : (pOne ? 1 : 0);
    pOne = 0;
    pTwo = 0;
    @(negedge clk);
    rdEn = 1'b0;
    wrEn = 1'b0;
  endtask

  task automatic inj(input bit one, input bit two);
    @(negedge clk);
    injSingle = one; injDouble = two;
    pOne = pOne | one;
    pTwo = pTwo | two;
    @(negedge clk);
    injSingle = 1'b0; injDouble = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (R1) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs low during reset
    check({rdValid, corrErr, uncErr} == 3'b000, "R11 outputs in reset", {29'd0, rdValid, corrErr, uncErr}, 32'd0);
    rst_n = 1'b1;

    // R1/R2: basic placement with a 32-word lower region
    setSize(32);
    wr(0, 5, 32'hA5A5_0001);
    wr(1, 5, 32'h5A5A_0002);
    rd(0, 5, "R1");
    rd(1, 5, "R2");
    // R2: grow the lower region so word 37 (upper offset 5 before) is visible below
    setSize(40);
    rd(0, 37, "R2");
    setSize(32);

    // R3: folding of out-of-range offsets
    wr(1, 100, 32'hDEAD_BEEF);   // 100 - 96 -> upper offset 4, word 36
    rd(1, 4, "R3");
    wr(0, 33, 32'h0BAD_F00D);    // 33 - 32 -> lower offset 1
    rd(0, 1, "R3");

    // R1: assorted data patterns
    for (int i = 0; i < 8; i++) begin
      wr(0, 8 + i, (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (32'h1 << (i * 4)) ^ (32'h1357_9BDF * i));
    end
    for (int i = 0; i < 8; i++) rd(0, 8 + i, "R1");

    // R4: empty regions ignore accesses
    wr(0, 0, 32'h1111_2222);
    setSize(0);
    wr(0, 0, 32'h3333_4444);
    rdIgnored(0, 0, "R4");
    setSize(32);
    rd(0, 0, "R4");
    setSize(200);
    rdIgnored(1, 3, "R4");
    setSize(32);

    // R5/R7: single-bit injection, used once
    inj(1, 0);
    wr(1, 10, 32'hCAFE_0010);
    rd(1, 10, "R5");
    wr(1, 11, 32'hCAFE_0011);
    rd(1, 11, "R7");

    // R6: double-bit injection
    inj(0, 1);
    wr(1, 12, 32'h1234_5678);
    rd(1, 12, "R6");

    // R8: both pending, double wins; next write clean
    inj(1, 1);
    wr(1, 13, 32'h8765_4321);
    rd(1, 13, "R8");
    wr(1, 14, 32'h0F0F_F0F0);
    rd(1, 14, "R8");

    // R10: read and write to the same word in one cycle
    wr(0, 3, 32'hAAAA_5555);
    rdwr(0, 3, 32'h5555_AAAA, "R10");
    rd(0, 3, "R10");

    // R11: reset drops a pending injection
    inj(1, 0);
    @(negedge clk);
    rst_n = 1'b0;
    pOne = 0;
    pTwo = 0;
    @(negedge clk);
    check({rdValid, corrErr, uncErr} == 3'b000, "R11 outputs in reset", {29'd0, rdValid, corrErr, uncErr}, 32'd0);
    rst_n = 1'b1;
    wr(1, 20, 32'h7777_8888);
    rd(1, 20, "R11");

    repeat (4) @(negedge clk);
    check(expD.size() == 0, "R1 all reads answered", expD.size(), 32'd0);
    summary();
    $finish;
  end

endmodule